// File: doc/BRIEF.md
# Priority Output Queue Scheduler

This block decides, for one egress port, which output queue hands over the next packet retrieve address. Every priority level has two address banks: one is filled by even-numbered input ports and the other by odd-numbered input ports. Each bank reports an empty flag. The downstream device also supplies a send grant for each priority. On every scheduling slot the scheduler picks one granted, occupied priority and one of its two banks. It then raises a one-hot notify so that the bank can pop the head of its own FIFO.

Strict priority is the default, and priority 0 is the most urgent. A cyclic credit table can override that order. Each table entry names a preferred priority, and one entry is consumed per slot, which reserves a fixed share of slots for lower priorities. When both banks of the chosen priority hold addresses, successive selections alternate between them. Software loads the credit table through a small write port.

Top module: `pq_out_sched`

## Requirements
- R1: After reset `notifyValid` and `notifyOneHot` are zero, every credit entry names priority 0, the credit pointer is at entry 0 and every priority's bank toggle points at the even bank.
- R2: A `slotReq` sampled high at a clock edge yields its result on `notifyValid`/`notifyOneHot` after that edge, for exactly one cycle. A valid notify sets exactly bit `2*p+b`, where p is the priority and b is 0 for the even bank and 1 for the odd bank. Without a request both outputs are zero.
- R3: When no priority is eligible, the slot yields `notifyValid` low and `notifyOneHot` zero, and the credit pointer still advances.
- R4: A priority is eligible only when its `sendGrant` bit is 1 and at least one of its banks is not empty. A bank whose empty flag is set is never notified.
- R5: If the priority named by the current credit entry is eligible, that priority is selected.
- R6: If the credited priority is not eligible, the lowest-numbered eligible priority is selected.
- R7: The credit pointer advances by one entry on every slot request and wraps from the last entry (15) to entry 0. It holds when there is no request.
- R8: When both banks of the selected priority are occupied, that priority's selections alternate between the banks, starting with the even bank after reset. Each priority keeps its own toggle.
- R9: When only one bank of the selected priority is occupied, that bank is chosen and the priority's toggle is left unchanged.
- R10: A write with `cfgWe` high at an edge stores `cfgData` into the entry at `cfgAddr`. Slots requested after that edge use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slotReq | input | 1 | One scheduling slot per high cycle |
| evenEmpty | input | NUM_PRIO | Even-port bank empty, one bit per priority |
| oddEmpty | input | NUM_PRIO | Odd-port bank empty, one bit per priority |
| sendGrant | input | NUM_PRIO | Downstream grant, one bit per priority |
| cfgWe | input | 1 | Credit table write enable |
| cfgAddr | input | log2(TABLE_DEPTH) | Credit entry to write |
| cfgData | input | log2(NUM_PRIO) | Preferred priority for that entry |
| notifyValid | output | 1 | Notify is valid this cycle |
| notifyOneHot | output | 2*NUM_PRIO | One-hot notify, bit 2*p+bank |

## Verification
The bench drives banks that are occupied but not granted. A design that tests only occupancy would notify a priority the device cannot accept. It runs whole table cycles in which the credited priority is empty, which catches a fallback that picks the wrong level or stalls. It runs the pointer across its wrap point after loading a non-uniform table, so an off-by-one pointer shows up as a shifted preference pattern. It also alternates between runs where both banks are full and runs where one bank is full. A toggle that flips on single-bank picks would then start the next two-bank run on the wrong bank.

// File: rtl/pq_sched_pkg.sv
package pq_sched_pkg;

  // Widest priority index carried between control and datapath.
  localparam int MAX_PRIO_W = 8;

  typedef enum logic {
    BANK_EVEN = 1'b0,
    BANK_ODD  = 1'b1
  } bank_e;

  // Strobes from the control half to the selection datapath.
  typedef struct packed {
    logic                  slotGo;
    logic [MAX_PRIO_W-1:0] prefPrio;
  } ctrl_strobes_t;

endpackage

// File: rtl/pqs_ctrl.sv
module pqs_ctrl
  import pq_sched_pkg::*;
#(
  parameter int NUM_PRIO    = 4,
  parameter int TABLE_DEPTH = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               slotReq,
  input  logic                               cfgWe,
  input  logic [$clog2(TABLE_DEPTH)-1:0]     cfgAddr,
  input  logic [(NUM_PRIO>1 ? $clog2(NUM_PRIO) : 1)-1:0] cfgData,
  output ctrl_strobes_t                      strobes
);
  localparam int PW = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1;
  localparam int AW = $clog2(TABLE_DEPTH);
  localparam logic [AW-1:0] LAST = AW'(TABLE_DEPTH - 1);

  logic [PW-1:0] creditTab [TABLE_DEPTH];
  logic [AW-1:0] slotPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TABLE_DEPTH; i++) creditTab[i] <= '0;
    end else if (cfgWe) begin
      creditTab[cfgAddr] <= cfgData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        slotPtr <= '0;
    else if (slotReq) slotPtr <= (slotPtr == LAST) ? '0 : slotPtr + 1'b1;
  end

  always_comb begin
    strobes          = '0;
    strobes.slotGo   = slotReq;
    strobes.prefPrio = MAX_PRIO_W'(creditTab[slotPtr]);
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    slotReq |=> slotPtr == (($past(slotPtr) == LAST) ? '0 : $past(slotPtr) + 1'b1))
    else $error("pointer did not step"); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !slotReq |=> $stable(slotPtr))
    else $error("pointer moved without request"); // R7

endmodule

// File: rtl/pqs_datapath.sv
module pqs_datapath
  import pq_sched_pkg::*;
#(
  parameter int NUM_PRIO = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobes_t         strobes,
  input  logic [NUM_PRIO-1:0]   evenEmpty,
  input  logic [NUM_PRIO-1:0]   oddEmpty,
  input  logic [NUM_PRIO-1:0]   sendGrant,
  output logic                  notifyValid,
  output logic [2*NUM_PRIO-1:0] notifyOneHot
);
  localparam int PW = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1;
  localparam int OW = 2 * NUM_PRIO;

  logic [NUM_PRIO-1:0] eligible;
  logic [NUM_PRIO-1:0] bankTog;
  logic [PW-1:0]       strictPrio, prefPrio, selPrio;
  logic                prefOk, anyElig, bothOcc;
  bank_e               selBank;

  assign eligible = (~evenEmpty | ~oddEmpty) & sendGrant;
  assign anyElig  = |eligible;
  assign prefPrio = strobes.prefPrio[PW-1:0];

  always_comb begin
    strictPrio = '0;
    for (int p = NUM_PRIO - 1; p >= 0; p--) begin
      if (eligible[p]) strictPrio = PW'(p);
    end
    prefOk = 1'b0;
    if (int'(strobes.prefPrio) < NUM_PRIO) prefOk = eligible[prefPrio];
    selPrio = prefOk ? prefPrio : strictPrio;
    bothOcc = !evenEmpty[selPrio] && !oddEmpty[selPrio];
    if (bothOcc)                selBank = bank_e'(bankTog[selPrio]);
    else if (evenEmpty[selPrio]) selBank = BANK_ODD;
    else                        selBank = BANK_EVEN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      notifyValid  <= 1'b0;
      notifyOneHot <= '0;
      bankTog      <= '0;
    end else if (strobes.slotGo && anyElig) begin
      notifyValid  <= 1'b1;
      notifyOneHot <= OW'(1) << {selPrio, selBank};
      if (bothOcc) bankTog[selPrio] <= ~bankTog[selPrio];
    end else begin
      notifyValid  <= 1'b0;
      notifyOneHot <= '0;
    end
  end

  AST_ONE_NOTIFY: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> $onehot(notifyOneHot))
    else $error("notify not one-hot"); // R2
  AST_NOTIFY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> $past(strobes.slotGo))
    else $error("notify without request"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !notifyValid |-> notifyOneHot == '0)
    else $error("stray notify bit"); // R3
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.slotGo |=> $stable(bankTog))
    else $error("toggle moved without slot"); // R9

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_chk
    AST_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
      (notifyOneHot[2*p] || notifyOneHot[2*p+1]) |-> $past(sendGrant[p]))
      else $error("ungranted priority notified"); // R4
    AST_EVEN_OCC: assert property (@(posedge clk) disable iff (!rstN)
      notifyOneHot[2*p] |-> !$past(evenEmpty[p]))
      else $error("empty even bank notified"); // R4
    AST_ODD_OCC: assert property (@(posedge clk) disable iff (!rstN)
      notifyOneHot[2*p+1] |-> !$past(oddEmpty[p]))
      else $error("empty odd bank notified"); // R4
  end

endmodule

// File: rtl/pq_out_sched.sv
module pq_out_sched
  import pq_sched_pkg::*;
#(
  parameter int NUM_PRIO    = 4,
  parameter int TABLE_DEPTH = 16
) (
  input  logic                                           clk,
  input  logic                                           rstN,
  input  logic                                           slotReq,
  input  logic [NUM_PRIO-1:0]                            evenEmpty,
  input  logic [NUM_PRIO-1:0]                            oddEmpty,
  input  logic [NUM_PRIO-1:0]                            sendGrant,
  input  logic                                           cfgWe,
  input  logic [$clog2(TABLE_DEPTH)-1:0]                 cfgAddr,
  input  logic [(NUM_PRIO>1 ? $clog2(NUM_PRIO) : 1)-1:0] cfgData,
  output logic                                           notifyValid,
  output logic [2*NUM_PRIO-1:0]                          notifyOneHot
);
  ctrl_strobes_t strobes;

  pqs_ctrl #(.NUM_PRIO(NUM_PRIO), .TABLE_DEPTH(TABLE_DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .slotReq(slotReq),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .strobes(strobes)
  );

  pqs_datapath #(.NUM_PRIO(NUM_PRIO)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .evenEmpty(evenEmpty), .oddEmpty(oddEmpty), .sendGrant(sendGrant),
    .notifyValid(notifyValid), .notifyOneHot(notifyOneHot)
  );

endmodule

// File: tb/test_pq_out_sched.sv
`timescale 1ns/1ps
module test_pq_out_sched;
  localparam int NP = 4;
  localparam int TD = 16;
  localparam int PW = 2;
  localparam int AW = 4;
  localparam int OW = 2 * NP;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          slotReq = 1'b0;
  logic [NP-1:0] evenEmpty = '1, oddEmpty = '1, sendGrant = '1;
  logic          cfgWe = 1'b0;
  logic [AW-1:0] cfgAddr = '0;
  logic [PW-1:0] cfgData = '0;
  logic          notifyValid;
  logic [OW-1:0] notifyOneHot;

  always #2.5 clk = ~clk;

  pq_out_sched #(.NUM_PRIO(NP), .TABLE_DEPTH(TD)) i_pq_out_sched (
    .clk(clk), .rstN(rstN), .slotReq(slotReq),
    .evenEmpty(evenEmpty), .oddEmpty(oddEmpty), .sendGrant(sendGrant),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .notifyValid(notifyValid), .notifyOneHot(notifyOneHot)
  );

  typedef struct {
    logic          v;
    logic [OW-1:0] oh;
    string         tag;
  } exp_t;

  exp_t        expQ[$];
  logic [PW-1:0] mTab [TD];
  int          mPtr;
  logic [NP-1:0] mTog;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  // Driver: called at a negedge; predicts and issues one slot.
  task automatic slot(input logic [NP-1:0] ev, input logic [NP-1:0] od,
                      input logic [NP-1:0] gr, input string tag);
    exp_t e;
    logic [NP-1:0] el;
    int pref, sel, b;
    evenEmpty = ev; oddEmpty = od; sendGrant = gr; slotReq = 1'b1;
    el = (~ev | ~od) & gr;
    e.tag = tag; e.v = 1'b0; e.oh = '0;
    if (el != '0) begin
      pref = int'(mTab[mPtr]);
      if (el[pref]) sel = pref;
      else begin
        sel = -1;
        for (int p = 0; p < NP; p++) if (el[p] && sel < 0) sel = p;
      end
      if (!ev[sel] && !od[sel]) begin
        b = int'(mTog[sel]);
        mTog[sel] = ~mTog[sel];
      end else b = ev[sel] ? 1 : 0;
      e.v = 1'b1;
      e.oh = OW'(1) << (2 * sel + b);
    end
    mPtr = (mPtr + 1) % TD;
    @(posedge clk);
    expQ.push_back(e);
    @(negedge clk);
    slotReq = 1'b0;
  endtask

  task automatic cfgWrite(input int addr, input int data);
    cfgWe = 1'b1; cfgAddr = AW'(addr); cfgData = PW'(data);
    @(posedge clk);
    mTab[addr] = PW'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Monitor: compares outputs against predictions between edges.
  always @(negedge clk) begin
    exp_t e;
    if (rstN && !done) begin
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (notifyValid !== e.v || notifyOneHot !== e.oh) begin
          fails++;
          $display("FAIL %s: valid/notify got %b/%b expected %b/%b",
                   e.tag, notifyValid, notifyOneHot, e.v, e.oh);
        end
      end else if (notifyValid !== 1'b0 || notifyOneHot !== '0) begin
        checks++;
        fails++;
        $display("FAIL R2: unrequested notify got %b/%b expected 0/0",
                 notifyValid, notifyOneHot);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TD; i++) mTab[i] = '0;
    mPtr = 0; mTog = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checks++;
    if (notifyValid !== 1'b0 || notifyOneHot !== '0) begin
      fails++;
      $display("FAIL R1: reset outputs got %b/%b expected 0/0", notifyValid, notifyOneHot);
    end
    @(negedge clk);

    // R3: nothing occupied; occupied but no grant (R4)
    slot('1, '1, '1, "R3 all empty");
    slot('0, '0, '0, "R3 R4 no grant");
    slot('1, '1, '1, "R3 all empty again");

    // R1 R8: default table prefers priority 0, banks alternate from even
    for (int i = 0; i < 4; i++) slot('0, '0, '1, "R1 R5 R8 default table");

    // R4 R6: priority 0 not granted -> priority 1
    for (int i = 0; i < 3; i++) slot('0, '0, 4'b1110, "R4 R6 R8 grant mask");

    // R9: only odd bank of priority 1, then both again
    for (int i = 0; i < 3; i++) slot(4'b0011, '0, 4'b1110, "R9 single bank");
    for (int i = 0; i < 2; i++) slot('0, '0, 4'b1110, "R8 R9 resume toggle");

    // R10: load a descending pattern, then run across the wrap (R7)
    for (int i = 0; i < TD; i++) cfgWrite(i, 3 - (i % 4));
    for (int i = 0; i < 2 * TD + 3; i++) slot('0, '0, '1, "R5 R7 R10 credit cycle");

    // R6: credited priority 3 empty every time it comes up
    for (int i = 0; i < TD; i++) slot(4'b1000, 4'b1000, '1, "R6 fallback");
    // R6: credited priority 2 ungranted, only odd banks present
    for (int i = 0; i < TD; i++) slot('1 ^ 4'b0000, 4'b0000, 4'b1011, "R6 R9 odd only");

    // Randomised traffic with occasional table rewrites
    for (int i = 0; i < 300; i++) begin
      if (i % 37 == 5) cfgWrite(int'($urandom_range(TD - 1)), int'($urandom_range(NP - 1)));
      if (i % 11 == 3) @(negedge clk);
      slot(NP'($urandom), NP'($urandom), NP'($urandom | 32'h1), "R4 R5 R6 R8 R9 random");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule